// File: doc/BRIEF.md
# Dual-Modulus Pulse Swallow Feedback Divider

This block is the digital core of a frequency synthesizer's divider chain. The input clock stands for the prescaler's source. A dual-modulus prescaler divides it by P+1 or by P, and two counters steer it. The swallow counter decides how many prescaler cycles use the larger modulus. The main counter decides how many prescaler cycles make one output period. Together they give one comparison pulse every P×N+A input cycles. A separate reference divider gives one pulse every R input cycles. The parameter `HIGH_BAND` picks which pair of prescaler sizes the section uses. The input `mod_sel` picks one size from that pair.

The N, A, R and modulus-select inputs are meant to come from an upstream settings latch. The divider samples them only at its own period boundaries, so a period that is under way always finishes with the values it started with. An illegal setting is never loaded. In that case the block raises `cfg_err` and keeps running on the last legal values.

Top module: `pulse_swallow_div`

## Requirements
- R1: While the settings stay unchanged, consecutive `fb_pulse` assertions are exactly P×N+A clock cycles apart. N is `n_in`, A is `a_in`, and P is the prescaler size chosen by R2.
- R2: With `HIGH_BAND`=0, `mod_sel`=1 gives P=8 and `mod_sel`=0 gives P=16. With `HIGH_BAND`=1, `mod_sel`=1 gives P=64 and `mod_sel`=0 gives P=128.
- R3: A change to `n_in`, `a_in` or `mod_sel` made partway through a period leaves that period's length unchanged. The new values govern the period that begins at the next `fb_pulse`.
- R4: Values present on the inputs in the same cycle in which a feedback period ends are the ones loaded for the following period. The same holds for the reference divider.
- R5: A feedback setting with N<3 or A≥N sets `cfg_err` to 1 one cycle later and is never loaded. The feedback period stays at its last legal length. Once the setting is legal again, `cfg_err` returns to 0.
- R6: Consecutive `ref_pulse` assertions are exactly R clock cycles apart, where R is `r_in`, for R from 3 to 16383.
- R7: A reference setting with R<3 sets `cfg_err` to 1 and is never loaded. The reference period keeps its last legal length.
- R8: While `rst` is high, `fb_pulse`, `ref_pulse` and `cfg_err` are 0. During reset the block captures the input settings if they are legal. The first periods after reset therefore already have the lengths those settings define.
- R9: Each `fb_pulse` and each `ref_pulse` is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Prescaler modulus select (R2) |
| n_in | input | 11 | Main counter value N, legal 3..2047 |
| a_in | input | 7 | Swallow counter value A, legal 0..127 and below N |
| r_in | input | 14 | Reference divide ratio R, legal 3..16383 |
| fb_pulse | output | 1 | One-cycle comparison pulse every P×N+A cycles |
| ref_pulse | output | 1 | One-cycle reference pulse every R cycles |
| cfg_err | output | 1 | High while the presented setting is illegal |

## Verification
Two events can fall in the same cycle: the end of a feedback period, and a settings change or an illegal setting arriving at the inputs. The bench knows the current period length. It counts up to the last cycle before the closing edge and changes the inputs there. It then checks two things. The closing pulse must still arrive one cycle later. The next full period must follow the new legal value, or the retained value if the new one is illegal. Sweeps over both modulus modes, both prescaler bands, the smallest N and A at 0, 1 and N−1 measure each period against P×N+A, and a change made inside a period must sum to the old length.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
    localparam int unsigned N_W   = 11;
    localparam int unsigned A_W   = 7;
    localparam int unsigned R_W   = 14;
    localparam int unsigned N_MIN = 3;
    localparam int unsigned R_MIN = 3;

    typedef struct packed {
        logic           mod;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } fb_cfg_t;

    function automatic logic fb_legal(input logic [N_W-1:0] n, input logic [A_W-1:0] a);
        return (n >= N_W'(N_MIN)) && (N_W'(a) < n);
    endfunction
endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] ratio,
    output logic          tick
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(ratio - CW'(1)));
        cnt_d = tick ? '0 : CW'(cnt_q + CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psd_swallow_ctl.sv
`timescale 1ns/1ps
module psd_swallow_ctl #(
    parameter int unsigned NW = 11,
    parameter int unsigned AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [NW-1:0] n_lim,
    input  logic [AW-1:0] a_lim,
    output logic          swallow,
    output logic          wrap
);
    typedef struct packed {
        logic [AW-1:0] ac;
        logic [NW-1:0] nc;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        swallow = (st_q.ac < a_lim);
        wrap    = tick && (st_q.nc == NW'(n_lim - NW'(1)));
        if (wrap) begin
            st_d = '0;
        end else if (tick) begin
            st_d.nc = NW'(st_q.nc + NW'(1));
            if (swallow) st_d.ac = AW'(st_q.ac + AW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/psd_ref_div.sv
`timescale 1ns/1ps
module psd_ref_div #(
    parameter int unsigned RW    = 14,
    parameter int unsigned R_DEF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] r_in,
    input  logic          r_ok,
    output logic          ref_pulse,
    output logic [RW-1:0] r_act
);
    typedef struct packed {
        logic [RW-1:0] cnt;
        logic [RW-1:0] lim;
        logic          pulse;
    } ref_t;

    ref_t rs_d, rs_q;
    logic last;

    always_comb begin
        rs_d       = rs_q;
        last       = (rs_q.cnt == RW'(rs_q.lim - RW'(1)));
        rs_d.pulse = last;
        if (last) begin
            rs_d.cnt = '0;
            if (r_ok) rs_d.lim = r_in;
        end else begin
            rs_d.cnt = RW'(rs_q.cnt + RW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q.cnt   <= '0;
            rs_q.pulse <= 1'b0;
            rs_q.lim   <= r_ok ? r_in : RW'(R_DEF);
        end else begin
            rs_q <= rs_d;
        end
    end

    assign ref_pulse = rs_q.pulse;
    assign r_act     = rs_q.lim;
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter bit          HIGH_BAND = 1'b0,
    parameter int unsigned N_DEF     = 3,
    parameter int unsigned A_DEF     = 0,
    parameter int unsigned R_DEF     = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mod_sel,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    input  logic [R_W-1:0] r_in,
    output logic           fb_pulse,
    output logic           ref_pulse,
    output logic           cfg_err
);
    localparam int unsigned PC_W = HIGH_BAND ? 8 : 5;

    typedef struct packed {
        fb_cfg_t cfg;
        logic    pulse;
        logic    err;
    } top_t;

    top_t            st_d, st_q;
    logic [PC_W-1:0] p_one, p_zero, p_cur, ratio;
    logic            tick, swallow, wrap, fb_ok, r_ok;
    logic [N_W-1:0]  act_n;
    logic [A_W-1:0]  act_a;
    logic            act_mod;
    logic [R_W-1:0]  act_r;
    fb_cfg_t         cfg_in;

    generate
        if (HIGH_BAND) begin : g_high
            assign p_one  = PC_W'(64);
            assign p_zero = PC_W'(128);
        end else begin : g_low
            assign p_one  = PC_W'(8);
            assign p_zero = PC_W'(16);
        end
    endgenerate

    assign cfg_in  = '{mod: mod_sel, n: n_in, a: a_in};
    assign fb_ok   = fb_legal(n_in, a_in);
    assign r_ok    = (r_in >= R_W'(R_MIN));
    assign act_n   = st_q.cfg.n;
    assign act_a   = st_q.cfg.a;
    assign act_mod = st_q.cfg.mod;
    assign p_cur   = act_mod ? p_one : p_zero;
    assign ratio   = swallow ? PC_W'(p_cur + PC_W'(1)) : p_cur;

    psd_prescaler #(.CW(PC_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .ratio (ratio),
        .tick  (tick)
    );

    psd_swallow_ctl #(.NW(N_W), .AW(A_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .n_lim   (act_n),
        .a_lim   (act_a),
        .swallow (swallow),
        .wrap    (wrap)
    );

    psd_ref_div #(.RW(R_W), .R_DEF(R_DEF)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .r_in      (r_in),
        .r_ok      (r_ok),
        .ref_pulse (ref_pulse),
        .r_act     (act_r)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = wrap;
        st_d.err   = !fb_ok || !r_ok;
        if (wrap && fb_ok) st_d.cfg = cfg_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cfg   <= fb_ok ? cfg_in : '{mod: 1'b1, n: N_W'(N_DEF), a: A_W'(A_DEF)};
            st_q.pulse <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_pulse = st_q.pulse;
    assign cfg_err  = st_q.err;
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker
    import psd_pkg::*;
#(
    parameter bit HIGH_BAND = 1'b0
) (
    input logic           clk,
    input logic           rst,
    input logic           fb_pulse,
    input logic           ref_pulse,
    input logic [N_W-1:0] act_n,
    input logic [A_W-1:0] act_a,
    input logic           act_mod,
    input logic [R_W-1:0] act_r
);
    logic [31:0] fb_gap_q, fb_exp_q, ref_gap_q, ref_exp_q;
    logic        fb_arm_q, ref_arm_q;
    logic [31:0] p_val;

    assign p_val = HIGH_BAND ? (act_mod ? 32'd64 : 32'd128) : (act_mod ? 32'd8 : 32'd16);

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_gap_q  <= '0;
            fb_exp_q  <= '0;
            fb_arm_q  <= 1'b0;
            ref_gap_q <= '0;
            ref_exp_q <= '0;
            ref_arm_q <= 1'b0;
        end else begin
            if (fb_pulse) begin
                fb_gap_q <= 32'd1;
                fb_exp_q <= p_val * 32'(act_n) + 32'(act_a);
                fb_arm_q <= 1'b1;
            end else begin
                fb_gap_q <= fb_gap_q + 32'd1;
            end
            if (ref_pulse) begin
                ref_gap_q <= 32'd1;
                ref_exp_q <= 32'(act_r);
                ref_arm_q <= 1'b1;
            end else begin
                ref_gap_q <= ref_gap_q + 32'd1;
            end
        end
    end

    // R1
    fb_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse && fb_arm_q) |-> (fb_gap_q == fb_exp_q));

    // R6
    ref_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && ref_arm_q) |-> (ref_gap_q == ref_exp_q));

    // R3
    fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fb_pulse && !$past(rst)) |-> ($stable(act_n) && $stable(act_a) && $stable(act_mod)));

    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_pulse && !$past(rst)) |-> $stable(act_r));

    // R5
    legal_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (act_n >= N_W'(N_MIN)) && (N_W'(act_a) < act_n) && (act_r >= R_W'(R_MIN)));

    // R9
    fb_single_chk: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R9
    ref_single_chk: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);
endmodule

bind pulse_swallow_div psd_checker #(.HIGH_BAND(HIGH_BAND)) u_psd_chk (
    .clk       (clk),
    .rst       (rst),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .act_n     (act_n),
    .act_a     (act_a),
    .act_mod   (act_mod),
    .act_r     (act_r)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        mod_sel;
    logic [10:0] n_in;
    logic [6:0]  a_in;
    logic [13:0] r_in;
    logic        fb_lo, ref_lo, err_lo, fb_hi, ref_hi, err_hi;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;

    pulse_swallow_div #(.HIGH_BAND(1'b0)) u_pulse_swallow_div (
        .clk(clk), .rst(rst), .mod_sel(mod_sel), .n_in(n_in), .a_in(a_in), .r_in(r_in),
        .fb_pulse(fb_lo), .ref_pulse(ref_lo), .cfg_err(err_lo)
    );

    pulse_swallow_div #(.HIGH_BAND(1'b1)) u_pulse_swallow_div_hi (
        .clk(clk), .rst(rst), .mod_sel(mod_sel), .n_in(n_in), .a_in(a_in), .r_in(r_in),
        .fb_pulse(fb_hi), .ref_pulse(ref_hi), .cfg_err(err_hi)
    );

    function automatic int pval(input bit hi, input bit m);
        if (hi) return m ? 64 : 128;
        return m ? 8 : 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(input bit hi, input bit use_ref, output int gap);
        bit seen;
        gap  = 0;
        seen = 1'b0;
        while (!seen && gap < 140000) begin
            @(negedge clk);
            gap++;
            seen = use_ref ? (hi ? ref_hi : ref_lo) : (hi ? fb_hi : fb_lo);
        end
    endtask

    // Called at the sample point of a feedback pulse; returns there.
    task automatic run_case(input bit hi, input bit m, input int n, input int a,
                            input int old_len, output int new_len);
        int g;
        repeat (2) @(negedge clk);
        mod_sel = m;
        n_in    = 11'(n);
        a_in    = 7'(a);
        wait_pulse(hi, 1'b0, g);
        // R3: period under way keeps its old length
        chk(2 + g == old_len, "R3 mid-period change", 2 + g, old_len);
        new_len = pval(hi, m) * n + a;
        wait_pulse(hi, 1'b0, g);
        // R1 / R2: full period with the new setting
        chk(g == new_len, hi ? "R1 R2 high band period" : "R1 R2 low band period", g, new_len);
    endtask

    initial begin
        #(3_900_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int g, cur, cur_hi;
        int nlist[5] = '{3, 4, 5, 9, 200};
        rst     = 1'b1;
        mod_sel = 1'b1;
        n_in    = 11'd5;
        a_in    = 7'd2;
        r_in    = 14'd7;
        repeat (4) begin
            @(negedge clk);
            // R8: outputs quiet in reset
            chk(!fb_lo && !ref_lo && !err_lo, "R8 reset outputs", {fb_lo, ref_lo, err_lo}, 0);
        end
        rst = 1'b0;
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 42, "R8 setting captured in reset", g, 42);
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 42, "R1 steady period", g, 42);
        wait_pulse(1'b0, 1'b1, g);
        wait_pulse(1'b0, 1'b1, g);
        chk(g == 7, "R6 reference period", g, 7);
        chk(err_lo == 1'b0, "R5 no error on legal setting", err_lo, 0);

        // Low band sweep
        wait_pulse(1'b0, 1'b0, g);
        cur = 42;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 5; i++) begin
                for (int k = 0; k < 3; k++) begin
                    int a;
                    a = (k == 2) ? nlist[i] - 1 : k;
                    if (a > 127) a = 127;
                    run_case(1'b0, m[0], nlist[i], a, cur, cur);
                end
            end
        end
        // R9: pulse one cycle wide
        @(negedge clk);
        chk(fb_lo == 1'b0, "R9 feedback pulse width", fb_lo, 0);

        // High band sweep
        wait_pulse(1'b1, 1'b0, g);
        cur_hi = pval(1'b1, mod_sel) * int'(n_in) + int'(a_in);
        for (int m = 0; m < 2; m++) begin
            for (int n = 3; n <= 6; n += 3) begin
                run_case(1'b1, m[0], n, 0, cur_hi, cur_hi);
                run_case(1'b1, m[0], n, n - 1, cur_hi, cur_hi);
            end
        end

        // Boundary-cycle load (R4); current setting m=1 n=6 a=5 -> 53
        wait_pulse(1'b0, 1'b0, g);
        cur = 53;
        repeat (cur - 1) @(negedge clk);
        mod_sel = 1'b0; n_in = 11'd4; a_in = 7'd3;
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 1, "R4 closing pulse on time", g, 1);
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 67, "R4 value at boundary loaded", g, 67);
        cur = 67;

        // Illegal N at the boundary (R5)
        repeat (cur - 1) @(negedge clk);
        n_in = 11'd2;
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 1, "R5 closing pulse on time", g, 1);
        chk(err_lo == 1'b1, "R5 error flag for N below 3", err_lo, 1);
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 67, "R5 period held for N below 3", g, 67);

        // Illegal A equal to N (R5)
        n_in = 11'd5; a_in = 7'd5;
        wait_pulse(1'b0, 1'b0, g);
        chk(err_lo == 1'b1, "R5 error flag for A equal N", err_lo, 1);
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 67, "R5 period held for A equal N", g, 67);

        // Legal again
        mod_sel = 1'b1; a_in = 7'd4;
        @(negedge clk);
        @(negedge clk);
        chk(err_lo == 1'b0, "R5 error flag clears", err_lo, 0);
        wait_pulse(1'b0, 1'b0, g);
        wait_pulse(1'b0, 1'b0, g);
        chk(g == 44, "R1 period after recovery", g, 44);

        // Reference ratios (R6)
        for (int j = 0; j < 4; j++) begin
            int rv;
            rv = (j == 0) ? 3 : (j == 1) ? 4 : (j == 2) ? 16 : 1000;
            r_in = 14'(rv);
            wait_pulse(1'b0, 1'b1, g);
            wait_pulse(1'b0, 1'b1, g);
            chk(g == rv, "R6 reference ratio", g, rv);
            @(negedge clk);
            chk(ref_lo == 1'b0, "R9 reference pulse width", ref_lo, 0);
            wait_pulse(1'b0, 1'b1, g);
        end

        // Illegal reference ratios (R7); current R=1000
        for (int j = 0; j < 3; j++) begin
            r_in = 14'(2 - j);
            wait_pulse(1'b0, 1'b1, g);
            chk(err_lo == 1'b1, "R7 error flag for small R", err_lo, 1);
            wait_pulse(1'b0, 1'b1, g);
            chk(g == 1000, "R7 reference period held", g, 1000);
        end
        r_in = 14'd5;
        wait_pulse(1'b0, 1'b1, g);
        wait_pulse(1'b0, 1'b1, g);
        chk(g == 5, "R6 reference after recovery", g, 5);

        // Largest legal feedback setting
        wait_pulse(1'b0, 1'b0, g);
        run_case(1'b0, 1'b1, 2047, 127, 44, cur);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule